// File: doc/BRIEF.md
# Bidirectional Open-Drain Line Repeater

This block joins a host-side line and a card-side line. Both are open-drain and both rest high. Whichever side pulls low first takes control of the pair. The block then copies that low onto the opposite side after a programmable delay. Each side has a sampled line input, a pull-low enable output and a boost flag. The boost flag asks an external driver to push the line hard to high for a short time when a low is released.

Arbitration runs on falling edges only. While one side is in control, edges on the other side are ignored. This stops the pair from holding itself low. When the controlling side lets go, the block releases the far side and raises the far side's boost flag for the same delay. It then goes back to waiting. A side that is still low at that point cannot start a new transfer. Only a fresh falling edge can start one, so a conflict clears once both sides have been released. One instance of the logic is built for each line, and the lanes run independently. A disable input releases every output and holds every lane at rest.

Top module: `line_repeater`

## Requirements
- R1: After reset, every pull-low and boost output is 0 (1 means pull the line low / boost it high).
- R2: A host line that falls while the lane rests, sampled low first at clock edge E, sets the lane's card pull output after edge E+2+DELAY.
- R3: A card line that falls while the lane rests, sampled low first at clock edge E, sets the lane's host pull output after edge E+2+DELAY.
- R4: While one side controls a lane, falling or rising activity on the other side changes no output of that lane.
- R5: When the controlling line is sampled high first at edge E while the far pull is set, the far pull clears and the far boost sets after edge E+2. The boost then stays set for DELAY cycles, and the lane returns to rest.
- R6: If the controlling line returns high before the delay runs out, the lane returns to rest. No pull and no boost is set.
- R7: If both lines of a lane fall in the same sample cycle, the host side takes control and only the card pull is set.
- R8: A line that is still low when its lane returns to rest starts nothing. Only a later high-to-low transition on that line starts a transfer.
- R9: With the disable input high at edge E, every output is 0 after edge E. Falling edges seen while disabled start nothing, including after the disable is removed.
- R10: Each lane of the vector ports operates independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rpt_off | input | 1 | Disable: release all outputs and hold lanes at rest |
| host_line_i | input | LINES | Host-side line levels, one bit per lane |
| card_line_i | input | LINES | Card-side line levels, one bit per lane |
| host_pull_o | output | LINES | Pull host line low |
| card_pull_o | output | LINES | Pull card line low |
| host_boost_o | output | LINES | Strong-high boost on host line |
| card_boost_o | output | LINES | Strong-high boost on card line |

## Verification
The in-line properties check several rules on every cycle. The two pull outputs of a lane are never set together. A boost only follows a pull on the same side. A pull only rises after its controlling line was sampled low. The disable input clears every output on the next edge. The exact latencies can only be shown by the scenario scoreboard. So can the ignoring of far-side edges, glitch rejection, same-cycle arbitration, conflict recovery without a new transfer, and lane independence. The scoreboard times every output transition against the cycle at which it is predicted.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
    typedef enum logic [2:0] {
        ST_REST,
        ST_H_WAIT,
        ST_H_DRIVE,
        ST_H_BOOST,
        ST_C_WAIT,
        ST_C_DRIVE,
        ST_C_BOOST
    } lane_st_e;
endpackage

// File: rtl/rpt_sync.sv
module rpt_sync #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/rpt_lane.sv
module rpt_lane
    import rpt_pkg::*;
#(
    parameter int DELAY = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic off_i,
    input  logic host_s_i,
    input  logic card_s_i,
    output logic host_pull_o,
    output logic card_pull_o,
    output logic host_boost_o,
    output logic card_boost_o
);
    localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY);
    localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

    typedef struct packed {
        lane_st_e      st;
        logic [CW-1:0] cnt;
        logic          h_prev;
        logic          c_prev;
    } lane_t;

    lane_t q, d;
    logic h_fall, c_fall;

    always_comb begin
        d        = q;
        d.h_prev = host_s_i;
        d.c_prev = card_s_i;
        h_fall   = q.h_prev & ~host_s_i;
        c_fall   = q.c_prev & ~card_s_i;
        unique case (q.st)
            ST_REST: begin
                d.cnt = '0;
                if (h_fall)      d.st = ST_H_WAIT;
                else if (c_fall) d.st = ST_C_WAIT;
            end
            ST_H_WAIT: begin
                if (host_s_i) begin
                    d.st  = ST_REST;
                    d.cnt = '0;
                end else if (q.cnt == LAST) begin
                    d.st  = ST_H_DRIVE;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_H_DRIVE: begin
                if (host_s_i) begin
                    d.st  = ST_H_BOOST;
                    d.cnt = '0;
                end
            end
            ST_H_BOOST: begin
                if (q.cnt == LAST) begin
                    d.st  = ST_REST;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_C_WAIT: begin
                if (card_s_i) begin
                    d.st  = ST_REST;
                    d.cnt = '0;
                end else if (q.cnt == LAST) begin
                    d.st  = ST_C_DRIVE;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_C_DRIVE: begin
                if (card_s_i) begin
                    d.st  = ST_C_BOOST;
                    d.cnt = '0;
                end
            end
            ST_C_BOOST: begin
                if (q.cnt == LAST) begin
                    d.st  = ST_REST;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: begin
                d.st  = ST_REST;
                d.cnt = '0;
            end
        endcase
        if (off_i) begin
            d.st  = ST_REST;
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= ST_REST;
            q.cnt    <= '0;
            q.h_prev <= 1'b1;
            q.c_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign card_pull_o  = (q.st == ST_H_DRIVE);
    assign host_pull_o  = (q.st == ST_C_DRIVE);
    assign card_boost_o = (q.st == ST_H_BOOST);
    assign host_boost_o = (q.st == ST_C_BOOST);

    // R4: only one direction is driven at a time
    a_r4_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_pull_o && card_pull_o));

    // R2: a card pull only starts after the host line was sampled low
    a_r2_drive_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_pull_o) |-> $past(!host_s_i));

    // R3: a host pull only starts after the card line was sampled low
    a_r3_drive_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_pull_o) |-> $past(!card_s_i));

    // R5: a boost only follows a pull on the same side
    a_r5_boost_after_pull: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_boost_o) |-> $past(card_pull_o));

    // R9: disable clears every output on the next edge
    a_r9_off_releases: assert property (@(posedge clk) disable iff (!rst_n)
        off_i |=> !(host_pull_o || card_pull_o || host_boost_o || card_boost_o));
endmodule

// File: rtl/line_repeater.sv
module line_repeater #(
    parameter int LINES = 3,
    parameter int DELAY = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rpt_off,
    input  logic [LINES-1:0] host_line_i,
    input  logic [LINES-1:0] card_line_i,
    output logic [LINES-1:0] host_pull_o,
    output logic [LINES-1:0] card_pull_o,
    output logic [LINES-1:0] host_boost_o,
    output logic [LINES-1:0] card_boost_o
);
    for (genvar g = 0; g < LINES; g++) begin : g_lane
        logic hs, cs;

        rpt_sync #(.RST_VAL(1'b1)) u_hsync (
            .clk(clk), .rst_n(rst_n), .d_i(host_line_i[g]), .q_o(hs));
        rpt_sync #(.RST_VAL(1'b1)) u_csync (
            .clk(clk), .rst_n(rst_n), .d_i(card_line_i[g]), .q_o(cs));

        rpt_lane #(.DELAY(DELAY)) u_lane (
            .clk          (clk),
            .rst_n        (rst_n),
            .off_i        (rpt_off),
            .host_s_i     (hs),
            .card_s_i     (cs),
            .host_pull_o  (host_pull_o[g]),
            .card_pull_o  (card_pull_o[g]),
            .host_boost_o (host_boost_o[g]),
            .card_boost_o (card_boost_o[g])
        );
    end
endmodule

// File: tb/sim_line_repeater.sv
module sim_line_repeater;
    localparam int L = 3;
    localparam int D = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rpt_off = 1'b0;
    logic [L-1:0] host_line = '1;
    logic [L-1:0] card_line = '1;
    logic [L-1:0] host_pull, card_pull, host_boost, card_boost;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    typedef struct {
        int    id;
        int    val;
        int    at;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    line_repeater #(.LINES(L), .DELAY(D)) u0 (
        .clk(clk), .rst_n(rst_n), .rpt_off(rpt_off),
        .host_line_i(host_line), .card_line_i(card_line),
        .host_pull_o(host_pull), .card_pull_o(card_pull),
        .host_boost_o(host_boost), .card_boost_o(card_boost)
    );

    // id = lane*4 + kind (0 host pull, 1 card pull, 2 host boost, 3 card boost)
    function automatic logic [4*L-1:0] outs();
        logic [4*L-1:0] v;
        for (int i = 0; i < L; i++) begin
            v[4*i+0] = host_pull[i];
            v[4*i+1] = card_pull[i];
            v[4*i+2] = host_boost[i];
            v[4*i+3] = card_boost[i];
        end
        return v;
    endfunction

    task automatic expect_chg(input int id, input int val, input int at, input string tag);
        exp_t e;
        e.id = id; e.val = val; e.at = at; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops one expected item per observed output transition
    logic [4*L-1:0] last_v = '0;
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                logic [4*L-1:0] v;
                v = outs();
                for (int b = 0; b < 4*L; b++) begin
                    if (v[b] != last_v[b]) begin
                        total++;
                        if (sb.size() == 0) begin
                            bad++;
                            $display("FAIL R4/R8 unexpected change id=%0d val=%0d cyc=%0d expected none",
                                     b, v[b], cyc);
                        end else begin
                            exp_t e;
                            e = sb.pop_front();
                            if (e.id != b || e.val != int'(v[b]) || e.at != cyc) begin
                                bad++;
                                $display("FAIL %s actual id=%0d val=%0d cyc=%0d expected id=%0d val=%0d cyc=%0d",
                                         e.tag, b, v[b], cyc, e.id, e.val, e.at);
                            end
                        end
                    end
                end
                last_v = v;
            end
        end
    end

    initial begin
        while (cyc < 20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual cyc=%0d expected done", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        wait_n(3);
        // R1: reset state
        total++;
        if (outs() != '0) begin
            bad++;
            $display("FAIL R1 reset outputs actual=%h expected=0", outs());
        end
        rst_n = 1'b1;
        wait_n(4);
        total++;
        if (outs() != '0) begin
            bad++;
            $display("FAIL R1 after reset outputs actual=%h expected=0", outs());
        end

        // R2: host falls first -> card pull
        n = cyc; host_line[0] = 1'b0;
        expect_chg(1, 1, n + 3 + D, "R2");
        wait_n(12);
        // R4: card activity while host controls is ignored
        card_line[0] = 1'b0;
        wait_n(4);
        // R5: host release -> card pull clears, card boost for D cycles
        n = cyc; host_line[0] = 1'b1;
        expect_chg(1, 0, n + 3, "R5");
        expect_chg(3, 1, n + 3, "R5");
        expect_chg(3, 0, n + 3 + D, "R5");
        wait_n(15);
        // R8: card still low at rest starts nothing
        wait_n(5);
        card_line[0] = 1'b1;
        wait_n(5);
        // R3: card falls first -> host pull
        n = cyc; card_line[0] = 1'b0;
        expect_chg(0, 1, n + 3 + D, "R3");
        wait_n(12);
        // R4: host glitch while card controls is ignored
        host_line[0] = 1'b0;
        wait_n(3);
        host_line[0] = 1'b1;
        wait_n(3);
        n = cyc; card_line[0] = 1'b1;
        expect_chg(0, 0, n + 3, "R5");
        expect_chg(2, 1, n + 3, "R5");
        expect_chg(2, 0, n + 3 + D, "R5");
        wait_n(15);

        // R6: short low inside the delay window -> nothing
        host_line[0] = 1'b0;
        wait_n(2);
        host_line[0] = 1'b1;
        wait_n(15);

        // R7: simultaneous fall -> host wins
        n = cyc; host_line[0] = 1'b0; card_line[0] = 1'b0;
        expect_chg(1, 1, n + 3 + D, "R7");
        wait_n(12);
        n = cyc; host_line[0] = 1'b1; card_line[0] = 1'b1;
        expect_chg(1, 0, n + 3, "R7");
        expect_chg(3, 1, n + 3, "R7");
        expect_chg(3, 0, n + 3 + D, "R7");
        wait_n(15);

        // R9: disable releases outputs and blocks edges
        n = cyc; host_line[0] = 1'b0;
        expect_chg(1, 1, n + 3 + D, "R2");
        wait_n(12);
        n = cyc; rpt_off = 1'b1;
        expect_chg(1, 0, n + 1, "R9");
        wait_n(3);
        host_line[0] = 1'b1;
        wait_n(3);
        host_line[0] = 1'b0;
        wait_n(4);
        rpt_off = 1'b0;
        wait_n(5);
        host_line[0] = 1'b1;
        wait_n(10);

        // R10: lanes independent (lane 1 host master, lane 2 card master)
        n = cyc; host_line[1] = 1'b0; card_line[2] = 1'b0;
        expect_chg(5, 1, n + 3 + D, "R10");
        expect_chg(8, 1, n + 3 + D, "R10");
        wait_n(12);
        n = cyc; host_line[1] = 1'b1; card_line[2] = 1'b1;
        expect_chg(5, 0, n + 3, "R10");
        expect_chg(7, 1, n + 3, "R10");
        expect_chg(8, 0, n + 3, "R10");
        expect_chg(10, 1, n + 3, "R10");
        expect_chg(7, 0, n + 3 + D, "R10");
        expect_chg(10, 0, n + 3 + D, "R10");
        wait_n(15);

        total++;
        if (sb.size() != 0) begin
            bad++;
            $display("FAIL R2/R10 missing transitions actual=%0d pending expected=0", sb.size());
        end
        total++;
        if (outs() != '0) begin
            bad++;
            $display("FAIL R5 final rest actual=%h expected=0", outs());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule